// File: doc/BRIEF.md
# Configurable Bidirectional Pad Cell

This cell sits between one device pad and the internal logic. On the inbound side the pad level is delivered to two internal taps, `i1` and `i2`. Each tap independently picks either the live pad level or the output of an input register. That register can be fed straight from the pad or through a short chain of shift stages. The chain lets the capture point trail the pad, so an external source has no hold-time demand to meet.

On the outbound side the value from the logic can be inverted by configuration. It then reaches the pad either combinationally or after an output register. A drive-enable, whose active level is also configured, controls the tri-state driver. With it the pin works as a bidirectional I/O or as an output only.

The driver is brought out as a split triple (`pad_o`, `pad_oe`, `pad_i`) for the pad macro to resolve. The inbound path samples `pad_i` whether or not the cell is driving. The input and output registers have separate clocks and share one synchronous reset.

Top module: `io_cell`

## Requirements
- R1: With `cfg_i1_reg`=0, `i1` equals `pad_i` with no clock edge in between.
- R2: `i2` selects its source from `cfg_i2_reg` (0 = live pad, 1 = input register), independently of the setting for `i1`.
- R3: With `cfg_in_delay`=0, the input register captures `pad_i` at each rising `in_clk` edge; a tap set to registered shows the level the pad had at the last edge.
- R4: With `cfg_in_delay`=1, the input register captures the pad level from DELAY_STAGES edges earlier. With the default of 2, a registered tap shows the pad as sampled three `in_clk` edges back.
- R5: The delay setting has no effect on a tap set to the live pad.
- R6: With `cfg_out_reg`=0, `pad_o` equals `core_out` when `cfg_out_inv`=0, and its complement when `cfg_out_inv`=1.
- R7: With `cfg_out_reg`=1, `pad_o` holds the possibly inverted `core_out` captured at the last rising `out_clk` edge.
- R8: `pad_oe` equals `core_oe` when `cfg_oe_inv`=0 and its complement when `cfg_oe_inv`=1 (1 = driving).
- R9: The inbound path keeps sampling `pad_i` while the cell drives the pad, so the driven level reads back on the taps.
- R10: A rising `in_clk` edge with `rst`=1 clears the input register and the delay stages. A rising `out_clk` edge with `rst`=1 clears the output register.
- R11: The input register changes only at `in_clk` edges and the output register only at `out_clk` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_clk | input | 1 | Clock of the input register and delay stages |
| out_clk | input | 1 | Clock of the output register |
| rst | input | 1 | Synchronous reset, active high, shared by both clocks |
| cfg_i1_reg | input | 1 | 1 = `i1` from input register, 0 = live pad |
| cfg_i2_reg | input | 1 | 1 = `i2` from input register, 0 = live pad |
| cfg_in_delay | input | 1 | 1 = input register fed through the delay stages |
| cfg_out_inv | input | 1 | 1 = invert the outbound value |
| cfg_out_reg | input | 1 | 1 = outbound value passes through the output register |
| cfg_oe_inv | input | 1 | 1 = drive-enable is active low |
| core_out | input | 1 | Outbound value from internal logic |
| core_oe | input | 1 | Drive-enable from internal logic |
| pad_i | input | 1 | Resolved pad level |
| pad_o | output | 1 | Value presented to the pad driver |
| pad_oe | output | 1 | Tri-state driver enable, 1 = drive |
| i1 | output | 1 | First inbound tap |
| i2 | output | 1 | Second inbound tap |

## Verification
A wrong delay-stage or input-register state shows on a registered tap as a pad level from the wrong edge. This is visible right after the next `in_clk` edge, and at most DELAY_STAGES+1 edges after the fault. A stale or wrongly inverted output register shows on `pad_o` right after the `out_clk` edge that loads it. Through the pad model it also reads back on a live tap in the same cycle. The bench probes between the two clock edges of every step, so an update made on the wrong clock appears within that step.

// File: rtl/io_cell.sv
module io_cell #(
  parameter int DELAY_STAGES = 2
) (
  input  logic in_clk,
  input  logic out_clk,
  input  logic rst,
  input  logic cfg_i1_reg,
  input  logic cfg_i2_reg,
  input  logic cfg_in_delay,
  input  logic cfg_out_inv,
  input  logic cfg_out_reg,
  input  logic cfg_oe_inv,
  input  logic core_out,
  input  logic core_oe,
  input  logic pad_i,
  output logic pad_o,
  output logic pad_oe,
  output logic i1,
  output logic i2
);

  logic in_d, in_q, out_d, out_q;

  if (DELAY_STAGES > 0) begin : g_dly
    logic [DELAY_STAGES-1:0] sr;
    always_ff @(posedge in_clk) begin
      if (rst) sr <= '0;
      else begin
        sr[0] <= pad_i;
        for (int k = 1; k < DELAY_STAGES; k++) sr[k] <= sr[k-1];
      end
    end
    assign in_d = cfg_in_delay ? sr[DELAY_STAGES-1] : pad_i;
  end else begin : g_nodly
    assign in_d = pad_i;
  end

  always_ff @(posedge in_clk) begin
    if (rst) in_q <= 1'b0;
    else     in_q <= in_d;
  end

  assign i1 = cfg_i1_reg ? in_q : pad_i;
  assign i2 = cfg_i2_reg ? in_q : pad_i;

  assign out_d = core_out ^ cfg_out_inv;

  always_ff @(posedge out_clk) begin
    if (rst) out_q <= 1'b0;
    else     out_q <= out_d;
  end

  assign pad_o  = cfg_out_reg ? out_q : out_d;
  assign pad_oe = core_oe ^ cfg_oe_inv;

  p_inreg_r3: assert property (@(posedge in_clk) disable iff (rst)
    (cfg_i1_reg && !$past(cfg_in_delay) && !$past(rst)) |-> (i1 == $past(pad_i)));

  if (DELAY_STAGES == 2) begin : g_chk_dly
    p_delay_r4: assert property (@(posedge in_clk) disable iff (rst)
      (cfg_i2_reg && $past(cfg_in_delay) && !$past(rst) && !$past(rst, 2) && !$past(rst, 3))
      |-> (i2 == $past(pad_i, 3)));
  end

  p_inv_direct_r6: assert property (@(posedge out_clk) disable iff (rst)
    (!cfg_out_reg && cfg_out_inv) |-> (pad_o != core_out));

  p_outreg_r7: assert property (@(posedge out_clk) disable iff (rst)
    (cfg_out_reg && !$past(rst)) |-> (pad_o == ($past(core_out) ^ $past(cfg_out_inv))));

  p_oe_pol_r8: assert property (@(posedge out_clk) disable iff (rst)
    cfg_oe_inv |-> (pad_oe != core_oe));

  p_in_clear_r10: assert property (@(posedge in_clk)
    rst |=> (!cfg_i1_reg || !i1));

  p_out_clear_r10: assert property (@(posedge out_clk)
    rst |=> (!cfg_out_reg || !pad_o));

endmodule

// File: tb/io_cell_test.sv
module io_cell_test;
  localparam int CLK_PERIOD = 10;
  localparam int DLY = 2;

  logic in_clk = 0, out_clk = 0, rst = 1;
  logic c_i1 = 0, c_i2 = 0, c_dly = 0, c_inv = 0, c_oreg = 0, c_oeinv = 0;
  logic core_out = 0, core_oe = 0, ext_val = 0;
  logic pad_o, pad_oe, i1, i2;
  wire  pad_i = pad_oe ? pad_o : ext_val;

  int checks = 0, fails = 0;
  bit m_hist[$];
  bit m_inq = 0, m_outq = 0;

  io_cell #(.DELAY_STAGES(DLY)) uut (
    .in_clk(in_clk), .out_clk(out_clk), .rst(rst),
    .cfg_i1_reg(c_i1), .cfg_i2_reg(c_i2), .cfg_in_delay(c_dly),
    .cfg_out_inv(c_inv), .cfg_out_reg(c_oreg), .cfg_oe_inv(c_oeinv),
    .core_out(core_out), .core_oe(core_oe), .pad_i(pad_i),
    .pad_o(pad_o), .pad_oe(pad_oe), .i1(i1), .i2(i2));

  function automatic bit e_oe();   return core_oe != c_oeinv; endfunction
  function automatic bit e_pado(); return c_oreg ? m_outq : (core_out != c_inv); endfunction
  function automatic bit e_pad();  return e_oe() ? e_pado() : ext_val; endfunction
  function automatic bit e_i1();   return c_i1 ? m_inq : e_pad(); endfunction
  function automatic bit e_i2();   return c_i2 ? m_inq : e_pad(); endfunction

  task automatic check(input string req, input string what, input logic act, input bit exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic string tag_in(input bit reg_sel);
    if (reg_sel) return c_dly ? "R4" : "R3";
    if (e_oe()) return "R9";
    return c_dly ? "R5" : "R1";
  endfunction

  task automatic check_all(input bit mid);
    check(mid ? "R11" : tag_in(c_i1), "i1", i1, e_i1());
    check(mid ? "R11" : (c_i2 ? "R2" : tag_in(0)), "i2", i2, e_i2());
    check(mid ? "R11" : (c_oreg ? "R7" : "R6"), "pad_o", pad_o, e_pado());
    check(mid ? "R11" : "R8", "pad_oe", pad_oe, e_oe());
  endtask

  task automatic step();
    bit p, tap;
    #(CLK_PERIOD/5);
    p = e_pad();
    if (rst) begin
      m_inq = 0;
      m_hist = {};
      for (int k = 0; k < DLY; k++) m_hist.push_back(0);
    end else begin
      tap = (DLY > 0) ? m_hist[DLY-1] : p;
      m_inq = c_dly ? tap : p;
      m_hist.push_front(p);
      void'(m_hist.pop_back());
    end
    in_clk = 1;
    #(CLK_PERIOD/10);
    check_all(1);
    #(CLK_PERIOD/10);
    m_outq = rst ? 1'b0 : (core_out != c_inv);
    out_clk = 1;
    #(CLK_PERIOD/5);
    in_clk = 0; out_clk = 0;
    #(CLK_PERIOD/5);
    check_all(0);
    #(CLK_PERIOD/5);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < DLY; k++) m_hist.push_back(0);
    ext_val = 1; core_out = 1; core_oe = 0;
    c_i1 = 1; c_i2 = 1; c_oreg = 1;
    repeat (2) step();
    // R10: registers read zero after reset edges even with pad and core high
    check("R10", "i1 after reset", i1, 1'b0);
    check("R10", "i2 after reset", i2, 1'b0);
    check("R10", "pad_o after reset", pad_o, 1'b0);
    rst = 0;
    for (int cfg = 0; cfg < 64; cfg++) begin
      {c_i1, c_i2, c_dly, c_inv, c_oreg, c_oeinv} = 6'(cfg);
      for (int n = 0; n < 12; n++) begin
        ext_val  = 1'($urandom_range(1));
        core_out = 1'($urandom_range(1));
        core_oe  = 1'($urandom_range(1));
        if (cfg == 37 && n == 5) rst = 1;
        step();
        rst = 0;
      end
    end
    // R9: readback of a driven level while the cell drives against an opposite external level
    {c_i1, c_i2, c_dly, c_inv, c_oreg, c_oeinv} = 6'b000000;
    core_oe = 1; core_out = 1; ext_val = 0;
    step();
    check("R9", "i1 readback high", i1, 1'b1);
    core_out = 0; ext_val = 1;
    step();
    check("R9", "i2 readback low", i2, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule